// File: doc/BRIEF.md
# Load-Linked Reservation Capture Unit

This unit serves load-linked requests of word (32-bit) and doubleword (64-bit) size. It accepts one request at a time and first checks that the virtual address is naturally aligned for the requested size. A misaligned request ends at once with an address-error-on-load exception. It then touches neither the translation port nor memory. When the core is not in debug mode, the faulting address is also latched in a bad-address register.

An aligned request is passed to an external translation port. A translation fault ends the request with a translation exception, and the reservation is left as it was. After a good translation, the unit reads memory at the physical address. It then captures three reservation items: the physical link address, the virtual address, and the loaded value (sign-extended for words). The loaded value is also returned as the result. A later conditional-store stage reads the exposed reservation outputs to make its own comparison.

Top module: `ll_reserve_unit`

## Requirements
- R1: A word request (`req_dword`=0) is misaligned when `req_vaddr[1:0]` is nonzero. A doubleword request (`req_dword`=1) is misaligned when `req_vaddr[2:0]` is nonzero. A misaligned request completes with `exc_valid`=1 and `exc_code`=1 (address error on load). A word request whose address has bits [1:0]=0 and bit 2=1 is aligned.
- R2: A misaligned request raises neither `xl_req` nor `mem_rd` at any cycle of its lifetime.
- R3: On a misaligned request with `req_debug`=0, `bad_vaddr` takes the request's virtual address. With `req_debug`=1, `bad_vaddr` keeps its previous value.
- R4: On a completed aligned request, `link_paddr` holds the physical address returned on `xl_paddr`, and `mem_addr` carries that same address while `mem_rd` is high.
- R5: On a completed aligned request, `link_vaddr` holds the request's virtual address.
- R6: For a word load, the result and `link_value` are `mem_rdata[31:0]` sign-extended from bit 31 to 64 bits.
- R7: For a doubleword load, the result and `link_value` equal `mem_rdata` unchanged. An exception reports a result of zero.
- R8: `req_ready` is high only while idle, so only one request is outstanding. A request is taken on a clock edge with `req_valid` and `req_ready` both high. `done` is a one-cycle pulse per request and is never high together with `req_ready`.
- R9: When `xl_done` comes with `xl_fault`=1, the request completes with `exc_code`=2, issues no memory read, and leaves `link_paddr`, `link_vaddr` and `link_value` unchanged.
- R10: After reset, `req_ready`=1, `done`=0, and `link_paddr`, `link_vaddr`, `link_value` and `bad_vaddr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_vaddr | input | XLEN | Effective virtual address |
| req_dword | input | 1 | 1 = doubleword, 0 = word |
| req_debug | input | 1 | Core is in debug mode |
| xl_req | output | 1 | Translation request, held until `xl_done` |
| xl_vaddr | output | XLEN | Address to translate |
| xl_done | input | 1 | Translation answer valid |
| xl_fault | input | 1 | Translation failed |
| xl_paddr | input | PA_W | Translated physical address |
| mem_rd | output | 1 | Memory read, held until `mem_done` |
| mem_addr | output | PA_W | Physical read address |
| mem_dword | output | 1 | Read size, 1 = doubleword |
| mem_done | input | 1 | Read data valid |
| mem_rdata | input | XLEN | Read data; a word sits in bits [31:0] |
| done | output | 1 | One-cycle completion pulse |
| result | output | XLEN | Loaded value, valid with `done` |
| exc_valid | output | 1 | Request ended in an exception |
| exc_code | output | 2 | 0 none, 1 address error on load, 2 translation fault |
| link_paddr | output | PA_W | Stored physical link address |
| link_vaddr | output | XLEN | Stored virtual link address |
| link_value | output | XLEN | Stored reservation value |
| bad_vaddr | output | XLEN | Last faulting virtual address |

## Verification
A misaligned request finishes exactly two clock edges after the edge that takes it. A translation fault finishes one edge after the edge that samples `xl_done`. A good load finishes one edge after the edge that samples `mem_done`. In every case the result, the exception code and the reservation outputs are valid together with `done`. The bench models both the translation and memory responders with a chosen latency. It counts the cycles in which `xl_req` and `mem_rd` are high, and it samples every output on the falling edge in the cycle `done` is high. From the request alone it predicts those counts (zero for a misaligned access, latency plus one otherwise) and all of the outputs. The cycle after `done` must show the pulse gone.

// File: rtl/llr_pkg.sv
package llr_pkg;
  typedef enum logic [1:0] {
    EXC_NONE      = 2'd0,
    EXC_ADDR_LOAD = 2'd1,
    EXC_XLATE     = 2'd2
  } llr_exc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_XLATE,
    ST_READ,
    ST_RESP
  } llr_state_e;
endpackage

// File: rtl/llr_align.sv
module llr_align #(
  parameter int OFF_W = 3
) (
  input  logic [OFF_W-1:0] offset,
  input  logic             is_dword,
  output logic             misaligned
);
  localparam int WORD_OFF_W = OFF_W - 1;

  function automatic logic off_bad(input logic [OFF_W-1:0] off, input logic dw);
    logic [OFF_W-1:0] mask;
    mask = dw ? {OFF_W{1'b1}} : {1'b0, {WORD_OFF_W{1'b1}}};
    return |(off & mask);
  endfunction

  assign misaligned = off_bad(offset, is_dword);

  always_comb begin
    if (!is_dword && offset[WORD_OFF_W-1:0] == '0)
      p_word_ok_r1: assert (!misaligned);
  end
endmodule

// File: rtl/llr_extend.sv
module llr_extend #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] rdata,
  input  logic            is_dword,
  output logic [XLEN-1:0] value
);
  localparam int HALF = XLEN / 2;

  function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] d, input logic dw);
    if (dw) return d;
    return {{HALF{d[HALF-1]}}, d[HALF-1:0]};
  endfunction

  assign value = widen(rdata, is_dword);
endmodule

// File: rtl/llr_ctrl.sv
module llr_ctrl
  import llr_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int PA_W = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [XLEN-1:0] req_vaddr,
  input  logic            req_dword,
  input  logic            req_debug,
  input  logic            misaligned,
  input  logic            xl_done,
  input  logic            xl_fault,
  input  logic [PA_W-1:0] xl_paddr,
  input  logic            mem_done,
  output logic            req_ready,
  output logic            xl_req,
  output logic            mem_rd,
  output logic            done,
  output llr_exc_e        exc_q,
  output logic [XLEN-1:0] cap_vaddr,
  output logic [PA_W-1:0] cap_paddr,
  output logic            cap_dword,
  output logic            cap_debug,
  output logic            misalign_evt,
  output logic            bad_we,
  output logic            resv_we
);
  llr_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      exc_q     <= EXC_NONE;
      cap_vaddr <= '0;
      cap_paddr <= '0;
      cap_dword <= 1'b0;
      cap_debug <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          cap_vaddr <= req_vaddr;
          cap_dword <= req_dword;
          cap_debug <= req_debug;
          exc_q     <= EXC_NONE;
          state     <= ST_CHECK;
        end
        ST_CHECK: begin
          if (misaligned) begin
            exc_q <= EXC_ADDR_LOAD;
            state <= ST_RESP;
          end else begin
            state <= ST_XLATE;
          end
        end
        ST_XLATE: if (xl_done) begin
          if (xl_fault) begin
            exc_q <= EXC_XLATE;
            state <= ST_RESP;
          end else begin
            cap_paddr <= xl_paddr;
            state     <= ST_READ;
          end
        end
        ST_READ: if (mem_done) state <= ST_RESP;
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign xl_req       = (state == ST_XLATE);
  assign mem_rd       = (state == ST_READ);
  assign done         = (state == ST_RESP);
  assign misalign_evt = (state == ST_CHECK) && misaligned;
  assign bad_we       = misalign_evt && !cap_debug;
  assign resv_we      = mem_rd && mem_done;

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);
  p_no_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_evt |=> (!xl_req && !mem_rd && done));
  p_fault_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && xl_done && xl_fault) |=> (!mem_rd && done));
endmodule

// File: rtl/llr_resv.sv
module llr_resv #(
  parameter int XLEN = 64,
  parameter int PA_W = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            resv_we,
  input  logic            bad_we,
  input  logic            misalign_evt,
  input  logic            in_debug,
  input  logic [XLEN-1:0] vaddr,
  input  logic [PA_W-1:0] paddr,
  input  logic [XLEN-1:0] value,
  output logic [PA_W-1:0] link_paddr,
  output logic [XLEN-1:0] link_vaddr,
  output logic [XLEN-1:0] link_value,
  output logic [XLEN-1:0] bad_vaddr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_paddr <= '0;
      link_vaddr <= '0;
      link_value <= '0;
    end else if (resv_we) begin
      link_paddr <= paddr;
      link_vaddr <= vaddr;
      link_value <= value;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bad_vaddr <= '0;
    else if (bad_we) bad_vaddr <= vaddr;
  end

  p_resv_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !resv_we |=> ($stable(link_paddr) && $stable(link_vaddr) && $stable(link_value)));
  p_debug_keeps_bad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (misalign_evt && in_debug) |=> $stable(bad_vaddr));
  p_bad_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (misalign_evt && !in_debug) |=> (bad_vaddr == $past(vaddr)));
endmodule

// File: rtl/ll_reserve_unit.sv
module ll_reserve_unit
  import llr_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int PA_W = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [XLEN-1:0] req_vaddr,
  input  logic            req_dword,
  input  logic            req_debug,
  output logic            xl_req,
  output logic [XLEN-1:0] xl_vaddr,
  input  logic            xl_done,
  input  logic            xl_fault,
  input  logic [PA_W-1:0] xl_paddr,
  output logic            mem_rd,
  output logic [PA_W-1:0] mem_addr,
  output logic            mem_dword,
  input  logic            mem_done,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            done,
  output logic [XLEN-1:0] result,
  output logic            exc_valid,
  output logic [1:0]      exc_code,
  output logic [PA_W-1:0] link_paddr,
  output logic [XLEN-1:0] link_vaddr,
  output logic [XLEN-1:0] link_value,
  output logic [XLEN-1:0] bad_vaddr
);
  localparam int OFF_W = $clog2(XLEN / 8);
  localparam int HALF  = XLEN / 2;

  llr_exc_e        exc_q;
  logic [XLEN-1:0] cap_vaddr;
  logic [PA_W-1:0] cap_paddr;
  logic            cap_dword;
  logic            cap_debug;
  logic            misaligned;
  logic            misalign_evt;
  logic            bad_we;
  logic            resv_we;
  logic [XLEN-1:0] ext_value;

  llr_align #(.OFF_W(OFF_W)) u_align (
    .offset     (cap_vaddr[OFF_W-1:0]),
    .is_dword   (cap_dword),
    .misaligned (misaligned)
  );

  llr_ctrl #(.XLEN(XLEN), .PA_W(PA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .req_dword    (req_dword),
    .req_debug    (req_debug),
    .misaligned   (misaligned),
    .xl_done      (xl_done),
    .xl_fault     (xl_fault),
    .xl_paddr     (xl_paddr),
    .mem_done     (mem_done),
    .req_ready    (req_ready),
    .xl_req       (xl_req),
    .mem_rd       (mem_rd),
    .done         (done),
    .exc_q        (exc_q),
    .cap_vaddr    (cap_vaddr),
    .cap_paddr    (cap_paddr),
    .cap_dword    (cap_dword),
    .cap_debug    (cap_debug),
    .misalign_evt (misalign_evt),
    .bad_we       (bad_we),
    .resv_we      (resv_we)
  );

  llr_extend #(.XLEN(XLEN)) u_extend (
    .rdata    (mem_rdata),
    .is_dword (cap_dword),
    .value    (ext_value)
  );

  llr_resv #(.XLEN(XLEN), .PA_W(PA_W)) u_resv (
    .clk          (clk),
    .rst_n        (rst_n),
    .resv_we      (resv_we),
    .bad_we       (bad_we),
    .misalign_evt (misalign_evt),
    .in_debug     (cap_debug),
    .vaddr        (cap_vaddr),
    .paddr        (cap_paddr),
    .value        (ext_value),
    .link_paddr   (link_paddr),
    .link_vaddr   (link_vaddr),
    .link_value   (link_value),
    .bad_vaddr    (bad_vaddr)
  );

  assign xl_vaddr  = cap_vaddr;
  assign mem_addr  = cap_paddr;
  assign mem_dword = cap_dword;
  assign exc_code  = exc_q;
  assign exc_valid = done && (exc_q != EXC_NONE);
  assign result    = (exc_q == EXC_NONE) ? link_value : '0;

  p_word_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !exc_valid && !cap_dword) |-> (result[XLEN-1:HALF] == {HALF{result[HALF-1]}}));
  p_read_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resv_we |=> (link_paddr == $past(mem_addr)));
  p_exc_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (result == '0));
endmodule

// File: tb/ll_reserve_unit_test.sv
module ll_reserve_unit_test;
  localparam int XLEN = 64;
  localparam int PA_W = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            req_valid = 1'b0, req_dword = 1'b0, req_debug = 1'b0;
  logic [XLEN-1:0] req_vaddr = '0;
  logic            req_ready;
  logic            xl_req, xl_done = 1'b0, xl_fault = 1'b0;
  logic [XLEN-1:0] xl_vaddr;
  logic [PA_W-1:0] xl_paddr = '0;
  logic            mem_rd, mem_dword, mem_done = 1'b0;
  logic [PA_W-1:0] mem_addr;
  logic [XLEN-1:0] mem_rdata = '0;
  logic            done, exc_valid;
  logic [1:0]      exc_code;
  logic [XLEN-1:0] result, link_vaddr, link_value, bad_vaddr;
  logic [PA_W-1:0] link_paddr;

  ll_reserve_unit #(.XLEN(XLEN), .PA_W(PA_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_dword(req_dword), .req_debug(req_debug),
    .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_done(xl_done), .xl_fault(xl_fault),
    .xl_paddr(xl_paddr), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_dword(mem_dword),
    .mem_done(mem_done), .mem_rdata(mem_rdata), .done(done), .result(result),
    .exc_valid(exc_valid), .exc_code(exc_code), .link_paddr(link_paddr),
    .link_vaddr(link_vaddr), .link_value(link_value), .bad_vaddr(bad_vaddr)
  );

  int checks = 0;
  int errors = 0;
  int xl_lat = 0;
  int mem_lat = 0;

  typedef struct {
    logic [63:0] res;
    logic [1:0]  exc;
    logic [63:0] lpa, lva, lval, bad;
    int          xl_cycles, mem_cycles;
  } item_t;
  item_t sb[$];

  logic [63:0] m_lpa = '0, m_lva = '0, m_lval = '0, m_bad = '0;

  function automatic logic [PA_W-1:0] xlate(input logic [63:0] va);
    return va[PA_W-1:0] ^ 40'hA5_0000_0000;
  endfunction
  function automatic logic [63:0] memword(input logic [PA_W-1:0] pa);
    return {~pa[31:0], pa[31:0] ^ 32'h8000_1234};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // translation responder
  initial begin
    forever begin
      @(negedge clk);
      if (xl_req) begin
        repeat (xl_lat) @(negedge clk);
        xl_paddr = xlate(xl_vaddr);
        xl_fault = xl_vaddr[62];
        xl_done  = 1'b1;
        @(negedge clk);
        xl_done  = 1'b0;
        xl_fault = 1'b0;
      end
    end
  end

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd) begin
        repeat (mem_lat) @(negedge clk);
        chk("R4 mem_addr", {24'd0, mem_addr}, {24'd0, link_paddr_exp()});
        mem_rdata = memword(mem_addr);
        mem_done  = 1'b1;
        @(negedge clk);
        mem_done  = 1'b0;
      end
    end
  end

  logic [PA_W-1:0] pend_pa = '0;
  function automatic logic [PA_W-1:0] link_paddr_exp();
    return pend_pa;
  endfunction

  // driver: called at a falling edge
  task automatic send(input logic [63:0] va, input logic dw, input logic dbg,
                      input int xl, input int ml);
    item_t it;
    logic mis, flt;
    logic [63:0] raw, val;
    logic [PA_W-1:0] pa;
    req_vaddr = va; req_dword = dw; req_debug = dbg; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    xl_lat = xl; mem_lat = ml;
    @(posedge clk);
    mis = dw ? (va[2:0] != 3'd0) : (va[1:0] != 2'd0);
    flt = va[62];
    pa  = xlate(va);
    raw = memword(pa);
    val = dw ? raw : 64'($signed(raw[31:0]));
    it.res = '0; it.xl_cycles = 0; it.mem_cycles = 0;
    if (mis) begin
      it.exc = 2'd1;
      if (!dbg) m_bad = va;
    end else if (flt) begin
      it.exc = 2'd2;
      it.xl_cycles = xl + 1;
    end else begin
      it.exc = 2'd0;
      it.xl_cycles = xl + 1;
      it.mem_cycles = ml + 1;
      m_lpa = {24'd0, pa}; m_lva = va; m_lval = val;
      it.res = val;
      pend_pa = pa;
    end
    it.lpa = m_lpa; it.lva = m_lva; it.lval = m_lval; it.bad = m_bad;
    sb.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    int xc = 0, mc = 0;
    logic prev_done = 1'b0;
    item_t e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (xl_req) xc++;
        if (mem_rd) mc++;
        if (done && prev_done) chk("R8 done pulse width", 64'(done), 64'd0);
        if (done) begin
          if (sb.size() == 0) begin
            chk("R8 unexpected done", 64'd1, 64'd0);
          end else begin
            e = sb.pop_front();
            chk("R1 R9 exc_code", 64'(exc_code), 64'(e.exc));
            chk("R1 exc_valid", 64'(exc_valid), 64'(e.exc != 2'd0));
            chk("R6 R7 result", result, e.res);
            chk("R4 link_paddr", {24'd0, link_paddr}, e.lpa);
            chk("R5 link_vaddr", link_vaddr, e.lva);
            chk("R6 R7 link_value", link_value, e.lval);
            chk("R3 bad_vaddr", bad_vaddr, e.bad);
            chk("R2 R9 xl_req cycles", 64'(xc), 64'(e.xl_cycles));
            chk("R2 R9 mem_rd cycles", 64'(mc), 64'(e.mem_cycles));
            chk("R8 ready low at done", 64'(req_ready), 64'd0);
          end
          xc = 0; mc = 0;
        end
        prev_done = done;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 req_ready", 64'(req_ready), 64'd1);
    chk("R10 done", 64'(done), 64'd0);
    chk("R10 link_paddr", {24'd0, link_paddr}, 64'd0);
    chk("R10 link_vaddr", link_vaddr, 64'd0);
    chk("R10 link_value", link_value, 64'd0);
    chk("R10 bad_vaddr", bad_vaddr, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready after release", 64'(req_ready), 64'd1);

    send(64'h0000_0000_1000_0010, 1'b0, 1'b0, 0, 0); // R6 negative word
    send(64'h0000_0008_8000_0028, 1'b1, 1'b0, 2, 1); // R7 dword
    send(64'h0000_0001_8000_0104, 1'b0, 1'b0, 1, 3); // R6 positive word
    send(64'h0000_0000_0000_3001, 1'b0, 1'b0, 0, 0); // R1 R3 word off 1
    send(64'h0000_0000_0000_4003, 1'b0, 1'b1, 0, 0); // R3 debug keeps bad
    send(64'h0000_0000_0000_5004, 1'b1, 1'b0, 0, 0); // R1 dword off 4
    send(64'h0000_0002_0000_6004, 1'b0, 1'b0, 0, 0); // R1 word off 4 aligned
    send(64'h4000_0000_0000_7008, 1'b0, 1'b0, 2, 0); // R9 translation fault
    send(64'h4000_0000_0000_7010, 1'b1, 1'b0, 0, 0); // R9 fault dword
    send(64'h0000_0000_0000_8002, 1'b1, 1'b1, 0, 0); // R3 dword off 2 debug
    send(64'h0000_0003_0000_9008, 1'b1, 1'b1, 1, 2); // R5 debug aligned ok
    send(64'h0000_0000_0000_A006, 1'b1, 1'b0, 0, 0); // R3 update again
    send(64'h0000_0004_7FFF_FFF8, 1'b0, 1'b0, 3, 0); // R6 word
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R8 idle ready", 64'(req_ready), 64'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule